// File: doc/BRIEF.md
# Single-Precision Floating-Point Multiplier

The block multiplies two normalized binary floating-point operands (single precision by default: one sign bit, an 8-bit biased exponent and a 23-bit fraction) and returns their product in the same format. Two flags come with it, one for an exponent that is too large and one for an exponent that is too small. Each operand is split into its fields. The implicit leading one is restored, the two significands are multiplied, and the exponents are added and the bias removed. The product is then normalized by at most one place and the final exponent is range-checked. Subnormal, NaN and infinity inputs are not supported, and the fraction is truncated, not rounded.

Operands enter on a valid/ready stream and results leave on a second valid/ready stream. With the output register enabled (`OUT_REG=1`), `in_ready` is high whenever the output slot is empty or is being drained in the same cycle. A result is held, unchanged, for as long as `out_ready` is low. With `OUT_REG=0` the path is purely combinational: `out_valid` follows `in_valid` and `in_ready` follows `out_ready` in the same cycle. The significand product comes either from a plain multiply (`MULT_ARCH=0`) or from a shifted partial-product array (`MULT_ARCH=1`). Both give bit-identical results.

Top module: `fpm_mul`

## Requirements
- R1: The result sign bit (the word MSB) equals the XOR of the two operand sign bits, including on overflow and underflow results.
- R2: When the significand product is at least 2.0 (top bit of the 2*(FRAC_W+1)-bit product set), the product is shifted right by one. The result exponent is then EA+EB-BIAS+1 and the fraction is the FRAC_W bits just below that top bit. BIAS is 2^(EXP_W-1)-1.
- R3: When the significand product is below 2.0, no shift is applied. The result exponent is EA+EB-BIAS and the fraction is the FRAC_W bits just below the product's second-highest bit, truncated.
- R4: A carry out of EA+EB beyond EXP_W bits is not an overflow when the result exponent after bias removal and normalization lies in 1..2^EXP_W-2. Such a result is produced normally with both flags low.
- R5: A final exponent of 2^EXP_W-1 or more raises the overflow flag, lowers the underflow flag, and outputs a signed infinity (exponent all ones, fraction zero).
- R6: An exponent after bias removal that is below zero, or that is exactly zero with no normalization shift, raises the underflow flag and outputs a signed zero (exponent and fraction zero).
- R7: An exponent after bias removal of exactly zero, combined with a normalization shift, is recovered: the result exponent is 1 and neither flag is set.
- R8: With `OUT_REG=1`, `in_ready` equals `!out_valid || out_ready`. While `out_valid` is high and `out_ready` low, `out_valid` stays high and `out_result` does not change on the next cycle.
- R9: With `OUT_REG=1`, every accepted operand pair produces exactly one result, in acceptance order, with none lost or duplicated.
- R10: During reset `out_valid` is low.
- R11: With `OUT_REG=0`, `out_valid` equals `in_valid` and `in_ready` equals `out_ready` in the same cycle, and the result is available in that cycle.
- R12: Both significand multiplier variants produce the results defined by R1 to R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock (used when OUT_REG=1) |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand pair valid |
| in_ready | output | 1 | Block can accept an operand pair |
| in_a | input | 1+EXP_W+FRAC_W | Operand A: sign, biased exponent, fraction (MSB to LSB) |
| in_b | input | 1+EXP_W+FRAC_W | Operand B, same layout |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Downstream accepts the result |
| out_result | output | 1+EXP_W+FRAC_W | Product in the operand layout |
| out_ovf | output | 1 | Exponent overflow, result is signed infinity |
| out_unf | output | 1 | Exponent underflow, result is signed zero |

## Verification
An exponent path that is too narrow would show at the ports on the first operand pair whose exponent sum carries or whose biased exponent goes negative. The symptom would be a wrapped exponent field, or an overflow or underflow flag that is wrong for that pair. A normalization fault would give a wrong exponent or fraction on roughly half of all operand pairs, so it would appear within the first few results. An output-stage fault would show within one cycle of the first stall, as a changed result or a dropped valid. It could also show as a count mismatch between accepted operands and delivered results. A reduced-width build is swept over every normalized operand pair, with back-pressure applied at random, so every exponent boundary is reached.

// File: rtl/fpm_pkg.sv
package fpm_pkg;
  // significand multiplier variants
  localparam int MUL_PLAIN = 0;
  localparam int MUL_ARRAY = 1;

  function automatic int bias_of(input int exp_w);
    return (1 << (exp_w - 1)) - 1;
  endfunction
endpackage

// File: rtl/fpm_sig_mult.sv
module fpm_sig_mult
  import fpm_pkg::*;
#(
  parameter int SIG_W = 24,
  parameter int ARCH  = MUL_PLAIN
) (
  input  logic [SIG_W-1:0]   a,
  input  logic [SIG_W-1:0]   b,
  output logic [2*SIG_W-1:0] prod
);
  localparam int PW = 2 * SIG_W;

  generate
    if (ARCH == MUL_ARRAY) begin : g_array
      logic [PW-1:0] acc [0:SIG_W];
      assign acc[0] = '0;
      for (genvar i = 0; i < SIG_W; i++) begin : g_row
        logic [PW-1:0] row;
        assign row        = b[i] ? ({{SIG_W{1'b0}}, a} << i) : '0;
        assign acc[i + 1] = acc[i] + row;
      end
      assign prod = acc[SIG_W];
    end else begin : g_plain
      assign prod = {{SIG_W{1'b0}}, a} * {{SIG_W{1'b0}}, b};
    end
  endgenerate
endmodule

// File: rtl/fpm_normalize.sv
module fpm_normalize #(
  parameter int FRAC_W = 23
) (
  input  logic [2*FRAC_W+1:0] prod,
  output logic                norm_inc,
  output logic [FRAC_W-1:0]   frac
);
  localparam int PW = 2 * FRAC_W + 2;

  assign norm_inc = prod[PW-1];

  always_comb begin
    if (norm_inc) frac = prod[PW-2 -: FRAC_W];
    else          frac = prod[PW-3 -: FRAC_W];
  end

  // both significands carry a hidden one, so the product is in [1.0, 4.0)
  always_comb begin
    AST_LEAD_ONE: assert (prod[PW-1] || prod[PW-2]); // R2
  end
endmodule

// File: rtl/fpm_exp_path.sv
module fpm_exp_path
  import fpm_pkg::*;
#(
  parameter int EXP_W = 8
) (
  input  logic [EXP_W-1:0] ea,
  input  logic [EXP_W-1:0] eb,
  input  logic             norm_inc,
  output logic [EXP_W-1:0] exp_out,
  output logic             ovf,
  output logic             unf
);
  localparam int XW   = EXP_W + 2;
  localparam int BIAS = bias_of(EXP_W);
  localparam int EMAX = (1 << EXP_W) - 1;

  logic [EXP_W:0]        sum_raw;
  logic signed [XW-1:0]  biased;
  logic signed [XW-1:0]  final_e;
  logic                  unf_lost;
  logic                  unf_edge;

  assign sum_raw  = {1'b0, ea} + {1'b0, eb};
  assign biased   = signed'({1'b0, sum_raw}) - signed'(XW'(BIAS));
  assign final_e  = biased + signed'({{(XW-1){1'b0}}, norm_inc});

  // below zero cannot be rescued; exactly zero is rescued only by a shift
  assign unf_lost = biased[XW-1];
  assign unf_edge = (biased == '0) && !norm_inc;
  assign unf      = unf_lost || unf_edge;
  assign ovf      = !unf && (final_e >= signed'(XW'(EMAX)));
  assign exp_out  = final_e[EXP_W-1:0];

  always_comb begin
    AST_FLAG_EXCL: assert (!(ovf && unf)); // R5
    AST_EXP_RANGE: assert (ovf || unf || (exp_out != '0 && exp_out != EXP_W'(EMAX))); // R6
  end
endmodule

// File: rtl/fpm_mul.sv
module fpm_mul
  import fpm_pkg::*;
#(
  parameter int EXP_W     = 8,
  parameter int FRAC_W    = 23,
  parameter int OUT_REG   = 1,
  parameter int MULT_ARCH = MUL_PLAIN
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        in_valid,
  output logic                        in_ready,
  input  logic [EXP_W+FRAC_W:0]       in_a,
  input  logic [EXP_W+FRAC_W:0]       in_b,
  output logic                        out_valid,
  input  logic                        out_ready,
  output logic [EXP_W+FRAC_W:0]       out_result,
  output logic                        out_ovf,
  output logic                        out_unf
);
  localparam int WORD_W = 1 + EXP_W + FRAC_W;
  localparam int SIG_W  = FRAC_W + 1;
  localparam int PW     = 2 * SIG_W;

  logic              sa, sb, res_sign;
  logic [EXP_W-1:0]  ea, eb, res_exp;
  logic [SIG_W-1:0]  siga, sigb;
  logic [PW-1:0]     prod;
  logic              norm_inc, c_ovf, c_unf;
  logic [FRAC_W-1:0] res_frac;
  logic [WORD_W-1:0] c_word;

  // field split with hidden one restored
  assign sa   = in_a[WORD_W-1];
  assign sb   = in_b[WORD_W-1];
  assign ea   = in_a[WORD_W-2 -: EXP_W];
  assign eb   = in_b[WORD_W-2 -: EXP_W];
  assign siga = {1'b1, in_a[FRAC_W-1:0]};
  assign sigb = {1'b1, in_b[FRAC_W-1:0]};
  assign res_sign = sa ^ sb;

  fpm_sig_mult #(.SIG_W(SIG_W), .ARCH(MULT_ARCH)) u_mult (
    .a(siga), .b(sigb), .prod(prod)
  );

  fpm_normalize #(.FRAC_W(FRAC_W)) u_norm (
    .prod(prod), .norm_inc(norm_inc), .frac(res_frac)
  );

  fpm_exp_path #(.EXP_W(EXP_W)) u_exp (
    .ea(ea), .eb(eb), .norm_inc(norm_inc),
    .exp_out(res_exp), .ovf(c_ovf), .unf(c_unf)
  );

  always_comb begin
    if (c_ovf)      c_word = {res_sign, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
    else if (c_unf) c_word = {res_sign, {EXP_W{1'b0}}, {FRAC_W{1'b0}}};
    else            c_word = {res_sign, res_exp, res_frac};
  end

  always_comb begin
    AST_SIGN_XOR: assert (c_word[WORD_W-1] == (in_a[WORD_W-1] ^ in_b[WORD_W-1])); // R1
  end

  generate
    if (OUT_REG != 0) begin : g_reg
      logic              vld_q, ovf_q, unf_q;
      logic [WORD_W-1:0] word_q;

      assign in_ready = !vld_q || out_ready;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          vld_q  <= 1'b0;
          ovf_q  <= 1'b0;
          unf_q  <= 1'b0;
          word_q <= '0;
        end else if (in_valid && in_ready) begin
          vld_q  <= 1'b1;
          ovf_q  <= c_ovf;
          unf_q  <= c_unf;
          word_q <= c_word;
        end else if (out_ready) begin
          vld_q  <= 1'b0;
        end
      end

      assign out_valid  = vld_q;
      assign out_result = word_q;
      assign out_ovf    = ovf_q;
      assign out_unf    = unf_q;

      AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_result)); // R8
      AST_OVF_INF: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_ovf |-> out_result[WORD_W-2:0] == {{EXP_W{1'b1}}, {FRAC_W{1'b0}}}); // R5
      AST_UNF_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_unf |-> out_result[WORD_W-2:0] == '0); // R6
      AST_READY_RULE: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready == (!out_valid || out_ready)); // R8
    end else begin : g_comb
      assign in_ready   = out_ready;
      assign out_valid  = in_valid;
      assign out_result = c_word;
      assign out_ovf    = c_ovf;
      assign out_unf    = c_unf;
    end
  endgenerate
endmodule

// File: tb/fpm_mul_tb.sv
module fpm_mul_tb;
  localparam int SE = 4;
  localparam int SF = 3;
  localparam int SW = 1 + SE + SF;
  localparam int NOPS  = 2 * ((1 << SE) - 2) * (1 << SF);
  localparam int TOTAL = NOPS * NOPS;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  // reduced build: registered, array multiplier
  logic          d_in_valid = 1'b0, d_in_ready, d_out_valid, d_out_ready = 1'b0;
  logic [SW-1:0] d_a = '0, d_b = '0, d_res;
  logic          d_ovf, d_unf;

  fpm_mul #(.EXP_W(SE), .FRAC_W(SF), .OUT_REG(1), .MULT_ARCH(1)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(d_in_valid), .in_ready(d_in_ready),
    .in_a(d_a), .in_b(d_b), .out_valid(d_out_valid), .out_ready(d_out_ready),
    .out_result(d_res), .out_ovf(d_ovf), .out_unf(d_unf)
  );

  // full single precision: combinational, plain multiplier
  logic        s_in_valid = 1'b0, s_in_ready, s_out_valid, s_out_ready = 1'b0;
  logic [31:0] s_a = '0, s_b = '0, s_res;
  logic        s_ovf, s_unf;

  fpm_mul #(.EXP_W(8), .FRAC_W(23), .OUT_REG(0), .MULT_ARCH(0)) u_sp (
    .clk(clk), .rst_n(rst_n), .in_valid(s_in_valid), .in_ready(s_in_ready),
    .in_a(s_a), .in_b(s_b), .out_valid(s_out_valid), .out_ready(s_out_ready),
    .out_result(s_res), .out_ovf(s_ovf), .out_unf(s_unf)
  );

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic string tag_name(input int t);
    case (t)
      2: return "R2";
      3: return "R3";
      4: return "R4";
      5: return "R5";
      6: return "R6";
      7: return "R7";
      default: return "R12";
    endcase
  endfunction

  // arithmetic model: returns {unf, ovf, word} packed into a longint plus a tag
  function automatic void fp_model(input longint a, input longint b, input int ew, input int fw,
                                   output longint packed_res, output int tag);
    longint fm, em, bias, s, ea, eb, fa, fb, p, e, frac, res;
    bit hi, ovf, unf;
    fm   = (longint'(1) << fw) - 1;
    em   = (longint'(1) << ew) - 1;
    bias = (longint'(1) << (ew - 1)) - 1;
    s    = ((a >> (ew + fw)) ^ (b >> (ew + fw))) & 1;
    ea   = (a >> fw) & em;
    eb   = (b >> fw) & em;
    fa   = a & fm;
    fb   = b & fm;
    p    = ((longint'(1) << fw) | fa) * ((longint'(1) << fw) | fb);
    hi   = p >= (longint'(1) << (2 * fw + 1));
    e    = ea + eb - bias;
    frac = hi ? ((p >> (fw + 1)) & fm) : ((p >> fw) & fm);
    tag  = (ea + eb > em) ? 4 : (hi ? 2 : 3);
    if (e == 0 && hi) tag = 7;
    if (hi) e = e + 1;
    ovf = 1'b0;
    unf = 1'b0;
    if (e >= em) begin
      ovf = 1'b1; tag = 5;
      res = (s << (ew + fw)) | (em << fw);
    end else if (e <= 0) begin
      unf = 1'b1; tag = 6;
      res = s << (ew + fw);
    end else begin
      res = (s << (ew + fw)) | (e << fw) | frac;
    end
    packed_res = (longint'(unf) << 41) | (longint'(ovf) << 40) | res;
  endfunction

  function automatic logic [SW-1:0] op_of(input int i);
    int sgn, r;
    sgn = i / (NOPS / 2);
    r   = i % (NOPS / 2);
    return SW'((sgn << (SE + SF)) | ((1 + r / (1 << SF)) << SF) | (r % (1 << SF)));
  endfunction

  task automatic sp_case(input logic [31:0] a, input logic [31:0] b, input longint lit, input bit use_lit);
    longint m, act;
    int t;
    s_a = a;
    s_b = b;
    s_in_valid  = 1'b1;
    s_out_ready = ~s_out_ready;
    #1;
    fp_model(longint'(a), longint'(b), 8, 23, m, t);
    act = (longint'(s_unf) << 41) | (longint'(s_ovf) << 40) | longint'(s_res);
    chk(act == m, tag_name(t), act, m); // R12 plain variant
    chk(s_res[31] == (a[31] ^ b[31]), "R1", longint'(s_res[31]), longint'(a[31] ^ b[31]));
    chk(s_out_valid == s_in_valid && s_in_ready == s_out_ready, "R11",
        longint'({s_out_valid, s_in_ready}), longint'({s_in_valid, s_out_ready}));
    if (use_lit) chk(longint'(s_res) == lit, tag_name(t), longint'(s_res), lit);
  endtask

  logic [31:0] rng = 32'h1234_5679;
  task automatic step_rng();
    rng ^= rng << 13;
    rng ^= rng >> 17;
    rng ^= rng << 5;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    longint q_exp[$];
    int     q_tag[$];
    int     k, outs;
    bit     prev_stall;
    logic [SW-1:0] held;

    repeat (3) @(negedge clk);
    chk(d_out_valid == 1'b0, "R10", longint'(d_out_valid), 0);
    rst_n = 1'b1;

    // single-precision directed cases
    @(negedge clk);
    sp_case(32'h4000_0000, 32'h4040_0000, 64'h40C0_0000, 1'b1);   // 2*3=6, R3
    sp_case(32'hC000_0000, 32'h4040_0000, 64'hC0C0_0000, 1'b1);   // -6, R1
    sp_case(32'h3FC0_0000, 32'h3FC0_0000, 64'h4010_0000, 1'b1);   // 1.5*1.5=2.25, R2
    sp_case(32'h1FC0_0000, 32'h2040_0000, 64'h0090_0000, 1'b1);   // recovered, R7
    sp_case(32'h1F80_0000, 32'h2000_0000, 64'h0000_0000, 1'b1);   // edge underflow, R6
    sp_case(32'h8080_0000, 32'h0080_0000, 64'h8000_0000, 1'b1);   // signed zero, R6
    sp_case(32'h7F00_0000, 32'h7F00_0000, 64'h7F80_0000, 1'b1);   // infinity, R5
    sp_case(32'h7F00_0000, 32'h3F80_0000, 64'h7F00_0000, 1'b1);   // carry absorbed, R4
    sp_case(32'h4049_0FDB, 32'hC02D_F854, 64'h0, 1'b0);
    sp_case(32'h3F7F_FFFF, 32'h3F7F_FFFF, 64'h0, 1'b0);

    // exhaustive sweep of the reduced build with random back-pressure
    k = 0;
    outs = 0;
    prev_stall = 1'b0;
    held = '0;
    while (outs < TOTAL) begin
      @(negedge clk);
      step_rng();
      d_in_valid  = (k < TOTAL) && (rng[3] || rng[9]);
      d_a         = op_of(k / NOPS);
      d_b         = op_of(k % NOPS);
      d_out_ready = rng[17] || rng[22];
      #1;
      if (prev_stall)
        chk(d_out_valid && d_res == held, "R8", longint'({d_out_valid, d_res}), longint'({1'b1, held}));
      chk(d_in_ready == (!d_out_valid || d_out_ready), "R8", longint'(d_in_ready),
          longint'(!d_out_valid || d_out_ready));
      if (d_out_valid && d_out_ready) begin
        if (q_exp.size() == 0) begin
          chk(1'b0, "R9", longint'(outs), longint'(k));
        end else begin
          longint e, act;
          int t;
          e = q_exp.pop_front();
          t = q_tag.pop_front();
          act = (longint'(d_unf) << 41) | (longint'(d_ovf) << 40) | longint'(d_res);
          chk(act == e, tag_name(t), act, e); // R12 array variant
          chk(d_res[SW-1] == e[SW-1], "R1", longint'(d_res[SW-1]), longint'(e[SW-1]));
        end
        outs++;
      end
      if (d_in_valid && d_in_ready) begin
        longint m;
        int t;
        fp_model(longint'(d_a), longint'(d_b), SE, SF, m, t);
        q_exp.push_back(m);
        q_tag.push_back(t);
        k++;
      end
      prev_stall = d_out_valid && !d_out_ready;
      held = d_res;
    end

    // drain: nothing extra may appear
    @(negedge clk);
    d_in_valid  = 1'b0;
    d_out_ready = 1'b1;
    repeat (3) @(negedge clk);
    chk(d_out_valid == 1'b0 && q_exp.size() == 0 && k == TOTAL, "R9",
        longint'(q_exp.size()), 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule